// File: doc/BRIEF.md
# Two-Level Interrupt Priority Controller

This block picks one interrupt to serve from a group of maskable peripheral sources and two sources that the mask cannot block: a non-maskable interrupt and an address-break request. Each maskable source has an enable bit and a one-bit level. A source at level 1 beats every source at level 0. Within a level, the lower source index wins. The non-maskable interrupt comes first of all, then the address break.

The CPU tells the block when an instruction has finished by raising `instrDone`. Only at that moment can a request be taken. When a request is taken, the block gives a one-clock accept pulse together with the winner's identifier and handler vector. It then holds a save-context request until the CPU reports that the program counter and flags are on the stack. After that it gives a one-clock request to set the CPU's global mask bit. No further request is taken until this sequence has finished.

From reset, and again after each set-mask request, the block treats the mask as set. It keeps doing so until it has seen the CPU's mask bit read 1 at least once. This stops a maskable request from slipping in before the CPU has updated the bit.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A maskable source whose enable bit is 0 is never accepted, whatever its request line does.
- R2: An eligible request at level 1 is accepted ahead of any request at level 0. Maskable requests follow their request lines, so a request that loses arbitration is accepted at a later boundary if its line is still high.
- R3: Among eligible maskable requests at the same level, the lowest source index is accepted first.
- R4: While the effective mask is 1, only the non-maskable interrupt (identifier 0) and the address break (identifier 1) are accepted; maskable requests wait.
- R5: A request is accepted only at a clock edge where `instrDone` is 1. `acceptPulse` is then high for exactly the following cycle.
- R6: `saveReq` is high from the accept cycle until the clock edge where `saveDone` is sampled 1. `setMaskReq` is then high for one cycle. No accept occurs from the accept pulse until `setMaskReq` has dropped.
- R7: Identifiers are 0 for the non-maskable interrupt, 1 for the address break, and i+2 for maskable source i. `vectorAddr` equals `VEC_BASE` + 4 × identifier. Both values are held until the next accept.
- R8: A rising edge on `nmiIn` sets a pending flag. That flag has priority over everything else and is cleared only when the non-maskable interrupt is accepted. A level held high does not cause a second accept. An edge that arrives during a handshake is not lost.
- R9: The effective mask is `maskBit` OR an internal force flag. The force flag is set by reset and by each `setMaskReq` cycle, and cleared at the first clock edge where `maskBit` is sampled 1.
- R10: After reset, `acceptPulse`, `saveReq` and `setMaskReq` are 0, `acceptId` is 0 and `vectorAddr` is `VEC_BASE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| srcReq | input | NUM_SRC | Level request lines of the maskable sources |
| srcEnable | input | NUM_SRC | Per-source enable bits |
| srcLevel | input | NUM_SRC | Per-source level (1 = high group) |
| nmiIn | input | 1 | Non-maskable interrupt, taken on its rising edge |
| addrBreakIn | input | 1 | Address-break request, level-sensitive |
| maskBit | input | 1 | CPU global interrupt-mask bit |
| instrDone | input | 1 | Instruction-boundary strobe |
| saveDone | input | 1 | CPU has finished saving PC and flags |
| acceptPulse | output | 1 | One-cycle pulse when a request is accepted |
| acceptId | output | ID_W | Identifier of the accepted request |
| vectorAddr | output | ADDR_W | Handler vector of the accepted request |
| saveReq | output | 1 | Request to save PC and flags |
| setMaskReq | output | 1 | One-cycle request to set the global mask bit |

## Verification
The arbitration is tested with pairs of requests that differ in only one respect:
- Two sources at the same level show whether the fixed index order is applied.
- A low-index source at level 0 paired with a high-index source at level 1 shows whether the level is checked before the index.
- A disabled source that is requesting shows whether the enable bit is honoured.

Masked patterns that combine a maskable request with an address break show whether the mask leaves the two unmaskable sources alone. Reset followed by a clear mask shows whether the force flag is applied. A non-maskable level held high across two boundaries tells edge capture apart from level sensing. An edge that arrives during the save handshake, and strobes raised while the handshake is in progress, show that pending state is kept and that a second accept is held off.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  // Strobes sent from the control FSM to the datapath
  typedef struct packed {
    logic capture;   // latch the current winner and clear a taken NMI
    logic armMask;   // force the effective mask to 1
  } ctrlStrobeT;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SAVE = 2'd1,
    ST_MASK = 2'd2
  } ctrlStateT;

  // Identifiers of the two sources that the mask cannot block
  localparam int ID_NMI  = 0;
  localparam int ID_ABRK = 1;
  localparam int ID_SRC0 = 2;

endpackage

// File: rtl/irq_prio_datapath.sv
module irq_prio_datapath
  import irq_prio_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W  = 16,
  parameter int ID_W    = 4,
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'h0100
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic [NUM_SRC-1:0] srcEnable,
  input  logic [NUM_SRC-1:0] srcLevel,
  input  logic               nmiIn,
  input  logic               addrBreakIn,
  input  logic               maskBit,
  input  ctrlStrobeT         strb,
  output logic               winValid,
  output logic [ID_W-1:0]    acceptId,
  output logic [ADDR_W-1:0]  vectorAddr
);

  localparam int SRC_IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic               nmiPrev;
  logic               nmiPend;
  logic               maskForce;
  logic               maskEff;
  logic [NUM_SRC-1:0] eligLo;
  logic [NUM_SRC-1:0] eligHi;
  logic [ID_W-1:0]    winId;
  logic               nmiRise;

  assign maskEff = maskBit | maskForce;
  assign nmiRise = nmiIn & ~nmiPrev;

  // Per-source eligibility: enabled, requesting, not masked
  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : gElig
    assign eligLo[gi] = srcReq[gi] & srcEnable[gi] & ~maskEff;
    assign eligHi[gi] = eligLo[gi] & srcLevel[gi];
  end

  function automatic logic [SRC_IDX_W-1:0] lowestIdx(input logic [NUM_SRC-1:0] v);
    lowestIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (v[i]) lowestIdx = SRC_IDX_W'(i);
    end
  endfunction

  // Winner: NMI, then address break, then level 1, then level 0
  always_comb begin
    winValid = 1'b1;
    winId    = '0;
    if (nmiPend) begin
      winId = ID_W'(ID_NMI);
    end else if (addrBreakIn) begin
      winId = ID_W'(ID_ABRK);
    end else if (|eligHi) begin
      winId = ID_W'(lowestIdx(eligHi)) + ID_W'(ID_SRC0);
    end else if (|eligLo) begin
      winId = ID_W'(lowestIdx(eligLo)) + ID_W'(ID_SRC0);
    end else begin
      winValid = 1'b0;
    end
  end

  // NMI edge capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nmiPrev <= 1'b0;
      nmiPend <= 1'b0;
    end else begin
      nmiPrev <= nmiIn;
      nmiPend <= nmiRise | (nmiPend & ~strb.capture);
    end
  end

  // Mask force flag: held until the CPU's bit is seen set
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskForce <= 1'b1;
    end else if (strb.armMask) begin
      maskForce <= 1'b1;
    end else if (maskBit) begin
      maskForce <= 1'b0;
    end
  end

  // Identifier and vector of the accepted request
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acceptId   <= '0;
      vectorAddr <= VEC_BASE;
    end else if (strb.capture) begin
      acceptId   <= winId;
      vectorAddr <= VEC_BASE + (ADDR_W'(winId) << 2);
    end
  end

  AST_NMI_CAPTURED: assert property (@(posedge clk) disable iff (!rstN)
    (nmiIn && !nmiPrev) |=> nmiPend); // R8

  AST_NMI_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && nmiPend) |=> (acceptId == ID_W'(ID_NMI))); // R8

  AST_MASK_ONLY_UNMASKABLE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && maskEff) |=> (acceptId < ID_W'(ID_SRC0))); // R4

  AST_FORCE_AFTER_ARM: assert property (@(posedge clk) disable iff (!rstN)
    strb.armMask |=> maskForce); // R9

  AST_DISABLED_NEVER_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && !nmiPend && !addrBreakIn) |=>
      srcEnable[acceptId - ID_W'(ID_SRC0)]); // R1

endmodule

// File: rtl/irq_prio_control.sv
module irq_prio_control
  import irq_prio_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       instrDone,
  input  logic       winValid,
  input  logic       saveDone,
  output ctrlStrobeT strb,
  output logic       acceptPulse,
  output logic       saveReq,
  output logic       setMaskReq
);

  ctrlStateT state, stateNext;

  always_comb begin
    strb         = '0;
    strb.capture = (state == ST_IDLE) && instrDone && winValid;
    strb.armMask = (state == ST_MASK);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (strb.capture) stateNext = ST_SAVE;
      ST_SAVE: if (saveDone)     stateNext = ST_MASK;
      ST_MASK:                   stateNext = ST_IDLE;
      default:                   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      acceptPulse <= 1'b0;
    end else begin
      state       <= stateNext;
      acceptPulse <= strb.capture;
    end
  end

  assign saveReq    = (state == ST_SAVE);
  assign setMaskReq = (state == ST_MASK);

  AST_ACCEPT_ONE_WIDE: assert property (@(posedge clk) disable iff (!rstN)
    acceptPulse |=> !acceptPulse); // R5

  AST_ACCEPT_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    acceptPulse |-> $past(instrDone)); // R5

  AST_ACCEPT_STARTS_SAVE: assert property (@(posedge clk) disable iff (!rstN)
    acceptPulse |-> saveReq); // R6

  AST_SAVE_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (saveReq && !saveDone) |=> saveReq); // R6

  AST_MASK_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(setMaskReq) |-> $past(saveDone)); // R6

  AST_MASK_ONE_WIDE: assert property (@(posedge clk) disable iff (!rstN)
    setMaskReq |=> !setMaskReq); // R6

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'h0100,
  localparam int ID_W = $clog2(NUM_SRC + 2)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic [NUM_SRC-1:0] srcEnable,
  input  logic [NUM_SRC-1:0] srcLevel,
  input  logic               nmiIn,
  input  logic               addrBreakIn,
  input  logic               maskBit,
  input  logic               instrDone,
  input  logic               saveDone,
  output logic               acceptPulse,
  output logic [ID_W-1:0]    acceptId,
  output logic [ADDR_W-1:0]  vectorAddr,
  output logic               saveReq,
  output logic               setMaskReq
);

  ctrlStrobeT strb;
  logic       winValid;

  irq_prio_datapath #(
    .NUM_SRC (NUM_SRC),
    .ADDR_W  (ADDR_W),
    .ID_W    (ID_W),
    .VEC_BASE(VEC_BASE)
  ) uDatapath (
    .clk        (clk),
    .rstN       (rstN),
    .srcReq     (srcReq),
    .srcEnable  (srcEnable),
    .srcLevel   (srcLevel),
    .nmiIn      (nmiIn),
    .addrBreakIn(addrBreakIn),
    .maskBit    (maskBit),
    .strb       (strb),
    .winValid   (winValid),
    .acceptId   (acceptId),
    .vectorAddr (vectorAddr)
  );

  irq_prio_control uControl (
    .clk        (clk),
    .rstN       (rstN),
    .instrDone  (instrDone),
    .winValid   (winValid),
    .saveDone   (saveDone),
    .strb       (strb),
    .acceptPulse(acceptPulse),
    .saveReq    (saveReq),
    .setMaskReq (setMaskReq)
  );

endmodule

// File: tb/irq_prio_ctrl_test.sv
`timescale 1ns/1ps
module irq_prio_ctrl_test;

  localparam int NSRC = 8;
  localparam int AW   = 16;
  localparam int IDW  = 4;
  localparam logic [AW-1:0] VBASE = 16'h0100;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NSRC-1:0] srcReq = '0, srcEnable = '0, srcLevel = '0;
  logic            nmiIn = 1'b0, addrBreakIn = 1'b0, maskBit = 1'b0;
  logic            instrDone = 1'b0, saveDone = 1'b0;
  logic            acceptPulse, saveReq, setMaskReq;
  logic [IDW-1:0]  acceptId;
  logic [AW-1:0]   vectorAddr;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  irq_prio_ctrl #(.NUM_SRC(NSRC), .ADDR_W(AW), .VEC_BASE(VBASE)) uut (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .srcEnable(srcEnable),
    .srcLevel(srcLevel), .nmiIn(nmiIn), .addrBreakIn(addrBreakIn),
    .maskBit(maskBit), .instrDone(instrDone), .saveDone(saveDone),
    .acceptPulse(acceptPulse), .acceptId(acceptId), .vectorAddr(vectorAddr),
    .saveReq(saveReq), .setMaskReq(setMaskReq)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model, evaluated on each rising edge
  int mState;   // 0 idle, 1 saving, 2 setting mask
  bit mNmiPrev, mNmiPend, mForce;
  bit eAcc, eSave, eMask;
  int eId, eVec;

  function automatic int pickWinner(bit eff);
    if (mNmiPend) return 0;
    if (addrBreakIn) return 1;
    if (eff) return -1;
    for (int i = 0; i < NSRC; i++)
      if (srcReq[i] && srcEnable[i] && srcLevel[i]) return i + 2;
    for (int i = 0; i < NSRC; i++)
      if (srcReq[i] && srcEnable[i]) return i + 2;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mNmiPrev = 0; mNmiPend = 0; mForce = 1;
      eAcc = 0; eSave = 0; eMask = 0; eId = 0; eVec = VBASE;
    end else begin
      bit eff, acc, rise;
      int win;
      eff  = maskBit | mForce;
      win  = pickWinner(eff);
      rise = nmiIn & !mNmiPrev;
      acc  = (mState == 0) && instrDone && (win >= 0);
      mNmiPend = rise | (mNmiPend & !(acc && win == 0));
      mNmiPrev = nmiIn;
      if (mState == 2) mForce = 1;
      else if (maskBit) mForce = 0;
      if (acc) begin
        eId = win; eVec = VBASE + 4 * win;
      end
      case (mState)
        0: if (acc) mState = 1;
        1: if (saveDone) mState = 2;
        default: mState = 0;
      endcase
      eAcc = acc; eSave = (mState == 1); eMask = (mState == 2);
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      chk(acceptPulse == eAcc, "R5 acceptPulse vs model", acceptPulse, eAcc);
      chk(acceptId == IDW'(eId), "R3 acceptId vs model", acceptId, eId);
      chk(vectorAddr == AW'(eVec), "R7 vectorAddr vs model", vectorAddr, eVec);
      chk(saveReq == eSave, "R6 saveReq vs model", saveReq, eSave);
      chk(setMaskReq == eMask, "R6 setMaskReq vs model", setMaskReq, eMask);
    end
  end

  // CPU side: save finishes on the third cycle; mask bit set on request
  int saveCnt = 0;
  always @(negedge clk) begin
    if (!saveReq) begin
      saveCnt  = 0;
      saveDone = 0;
    end else begin
      saveDone = (saveCnt == 2);
      saveCnt++;
    end
    if (setMaskReq) maskBit = 1;
  end

  task automatic pulseAccept(input int expId, input string tag);
    @(negedge clk) instrDone = 1;
    @(negedge clk) instrDone = 0;
    chk(acceptPulse == 1'b1, tag, acceptPulse, 1);
    chk(acceptId == IDW'(expId), tag, acceptId, expId);
    chk(vectorAddr == AW'(VBASE + 4 * expId), "R7 vector", vectorAddr, VBASE + 4 * expId);
  endtask

  task automatic pulseNone(input string tag);
    @(negedge clk) instrDone = 1;
    @(negedge clk) instrDone = 0;
    chk(acceptPulse == 1'b0, tag, acceptPulse, 0);
  endtask

  task automatic handler();
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (setMaskReq) break;
    end
    repeat (3) @(negedge clk);
    maskBit = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset values
    chk(acceptPulse == 0, "R10 acceptPulse", acceptPulse, 0);
    chk(saveReq == 0, "R10 saveReq", saveReq, 0);
    chk(setMaskReq == 0, "R10 setMaskReq", setMaskReq, 0);
    chk(acceptId == 0, "R10 acceptId", acceptId, 0);
    chk(vectorAddr == VBASE, "R10 vectorAddr", vectorAddr, VBASE);
    rstN = 1;

    // R9: mask is forced after reset until the bit reads 1
    srcEnable[3] = 1; srcReq[3] = 1;
    pulseNone("R9 forced mask after reset");
    @(negedge clk) maskBit = 1;
    @(negedge clk) maskBit = 0;
    pulseAccept(5, "R9 released");
    handler(); srcReq[3] = 0; srcEnable[3] = 0;

    // R1: disabled source ignored
    srcReq[2] = 1;
    pulseNone("R1 disabled source");
    srcReq[2] = 0;

    // R3: same level, lower index first; R2 loser remains pending
    srcEnable[1] = 1; srcEnable[4] = 1; srcReq[1] = 1; srcReq[4] = 1;
    pulseAccept(3, "R3 lower index first");
    handler(); srcReq[1] = 0;
    pulseAccept(6, "R2 pending loser accepted later");
    handler(); srcReq[4] = 0; srcEnable[1] = 0; srcEnable[4] = 0;

    // R2: level 1 beats lower index at level 0
    srcEnable[0] = 1; srcEnable[6] = 1; srcLevel[6] = 1; srcReq[0] = 1; srcReq[6] = 1;
    pulseAccept(8, "R2 level one wins");
    handler(); srcReq[6] = 0;
    pulseAccept(2, "R2 level zero next");
    handler(); srcReq[0] = 0; srcEnable[0] = 0;

    // R4: masked, only address break passes
    maskBit = 1; srcEnable[5] = 1; srcReq[5] = 1; addrBreakIn = 1;
    pulseAccept(1, "R4 address break under mask");
    handler(); maskBit = 1; addrBreakIn = 0;
    pulseNone("R4 maskable held");
    @(negedge clk) maskBit = 0;
    pulseAccept(7, "R4 maskable after unmask");
    handler(); srcReq[5] = 0; srcEnable[5] = 0;

    // R8: NMI edge wins, level does not retrigger, edge in handshake kept
    @(negedge clk) nmiIn = 1; addrBreakIn = 1; srcReq[6] = 1;
    pulseAccept(0, "R8 NMI first");
    handler();
    pulseAccept(1, "R8 no retrigger on held level");
    handler(); addrBreakIn = 0; nmiIn = 0;
    pulseAccept(8, "R8 maskable before edge");
    @(negedge clk) nmiIn = 1;
    handler();
    pulseAccept(0, "R8 edge during handshake kept");
    handler(); nmiIn = 0; srcReq[6] = 0; srcEnable[6] = 0; srcLevel[6] = 0;

    // R5: no accept without a boundary; R6: none during handshake
    srcEnable[7] = 1; srcReq[7] = 1;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chk(acceptPulse == 0, "R5 no boundary", acceptPulse, 0);
    end
    pulseAccept(9, "R5 boundary accept");
    @(negedge clk) instrDone = 1;
    chk(saveReq == 1, "R6 save held", saveReq, 1);
    @(negedge clk) instrDone = 0;
    chk(acceptPulse == 0, "R6 no second accept", acceptPulse, 0);
    handler(); srcReq[7] = 0; srcEnable[7] = 0;
    repeat (4) @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule